// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This block is the control logic of a byte-alterable parallel EEPROM, seen from the device side. It samples the active-low chip enable, output enable and write enable pins on a system clock and turns them into read and write cycles. A write cycle takes its address at the sample where chip enable and write enable first stand low together. It takes its data from the last sample before either of the two rises. Write pulses that are too short are discarded. Writes are also refused while output enable is low or while the inhibit input, which stands in for a low-supply detector, is high.

Accepted bytes collect in a 128-byte page buffer. The first accepted byte fixes the page, which is the address bits above bit 6. Each new write cycle must start within a load window of the previous one. When the window runs out with no write in progress, a self-timed programming phase begins. During this phase only the byte offsets that were loaded are copied into the behavioural memory array. While programming is under way, writes are ignored and reads return a busy word.

The output data bus is modelled as a value plus an output-enable flag. The enable is high only while both chip enable and output enable are sampled low.

Top module: `eeprom_page_seq`

## Requirements
- R1: `data_oe` is 1 one clock after a rising clock edge that samples both `ce_n` and `oe_n` low, and 0 otherwise. While `data_oe` is 0, `data_out` is 0.
- R2: Outside programming, an enabled read returns the array byte at the sampled `addr`. This holds while a page is still being loaded, in which case the read returns the old array contents.
- R3: A write stores to the address sampled at the first clock edge where `ce_n` and `we_n` are both low, whichever of the two fell last. Later address changes within the cycle have no effect.
- R4: A write stores the `data_in` sampled at the last clock edge where `ce_n` and `we_n` were both low, before whichever of the two rises first.
- R5: A write cycle whose joint-low phase lasts fewer than `GLITCH_CYC` sampled clocks is discarded.
- R6: A write cycle is discarded if `oe_n` is low or `wr_inhibit` is high at any sample of its joint-low phase.
- R7: The first accepted byte of a page fixes the page number, `addr[AW-1:7]`. Later bytes whose page number differs are discarded. A second byte to the same offset replaces the first. Up to 128 bytes fit in a page.
- R8: Programming starts once `LOAD_TMO` clocks have passed since the start of the latest write cycle, with no write cycle in progress. A write that starts inside that window keeps the page open.
- R9: During programming, write cycles are ignored. An enabled read returns bit 7 equal to the inverse of bit 7 of the last accepted byte, with bits 6:0 zero.
- R10: Programming lasts `PROG_CYC` clocks. Afterwards only the loaded offsets of the page hold the new bytes, all other array locations keep their values, and the block is ready for a new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_inhibit | input | 1 | High blocks all writes (low-supply stand-in) |
| addr | input | AW | Byte address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data toward the bus |
| data_oe | output | 1 | Bus drive enable; bus is high impedance when 0 |

## Verification
Write cycles are driven in three strobe orderings: both pins together, write enable first, and chip enable first. In each cycle the address changes after the latching sample and the data changes at the first rising strobe, so a capture on the wrong edge stores a wrong address or byte. Random page sessions mix in-page and foreign-page loads and repeat offsets. They use random gaps just inside the load window, which separates a timer that fires early from one that does not fire. A full 128-byte page and directed cycles that are short, inhibited, output-enabled or issued during programming then cover the discard paths. Each discard path is checked through later reads of the array and of the busy word.

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq #(
  parameter int AW         = 11,
  parameter int GLITCH_CYC = 2,
  parameter int LOAD_TMO   = 5000,
  parameter int PROG_CYC   = 250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          wr_inhibit,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data_in,
  output logic [7:0]    data_out,
  output logic          data_oe
);
  localparam int OFFW  = 7;
  localparam int PAGE  = 1 << OFFW;
  localparam int PGW   = AW - OFFW;
  localparam int DEPTH = 1 << AW;
  localparam int GW    = $clog2(GLITCH_CYC + 1);
  localparam int TW    = $clog2(LOAD_TMO + 1);
  localparam int PW    = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} st_t;
  st_t state;

  logic          ce_q, oe_q, we_q, inh_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    din_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_q <= 1'b1; oe_q <= 1'b1; we_q <= 1'b1; inh_q <= 1'b0;
      addr_q <= '0; din_q <= '0;
    end else begin
      ce_q <= ce_n; oe_q <= oe_n; we_q <= we_n; inh_q <= wr_inhibit;
      addr_q <= addr; din_q <= data_in;
    end

  // write cycle framing on the sampled strobes
  logic          pl_d, cyc_ok;
  logic [GW-1:0] lcnt;
  logic [AW-1:0] a_lat;
  logic [7:0]    d_lat;
  wire pins_low = !ce_q && !we_q;
  wire start    = pins_low && !pl_d;
  wire stop     = !pins_low && pl_d;
  wire qual     = oe_q && !inh_q && (state != ST_PROG);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pl_d <= 1'b0; cyc_ok <= 1'b0; lcnt <= '0; a_lat <= '0; d_lat <= '0;
    end else begin
      pl_d <= pins_low;
      if (start) begin
        a_lat  <= addr_q;
        lcnt   <= GW'(1);
        cyc_ok <= qual;
      end else if (pins_low) begin
        if (lcnt < GW'(GLITCH_CYC)) lcnt <= lcnt + 1'b1;
        cyc_ok <= cyc_ok && qual;
      end
      if (pins_low) d_lat <= din_q;
    end

  logic [PGW-1:0] page_q;
  logic [TW-1:0]  tmr;
  logic [PW-1:0]  pcnt;
  logic [PAGE-1:0] vld;
  logic           last_b7;

  wire accept = stop && cyc_ok && (lcnt >= GW'(GLITCH_CYC)) && (state != ST_PROG);
  wire same_pg = (state == ST_IDLE) || (a_lat[AW-1:OFFW] == page_q);
  wire load    = accept && same_pg;
  wire [OFFW-1:0] loff = a_lat[OFFW-1:0];
  wire tmo     = (state == ST_LOAD) && (tmr >= TW'(LOAD_TMO)) && !pins_low && !pl_d;
  wire sweep   = (state == ST_PROG) && (pcnt < PW'(PAGE));
  wire [OFFW-1:0] idx = pcnt[OFFW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE; page_q <= '0; tmr <= '0; pcnt <= '0; vld <= '0; last_b7 <= 1'b0;
    end else begin
      if (start) tmr <= '0;
      else if (tmr < TW'(LOAD_TMO)) tmr <= tmr + 1'b1;
      if (load) begin
        vld[loff] <= 1'b1;
        last_b7   <= d_lat[7];
      end
      if (sweep) vld[idx] <= 1'b0;
      case (state)
        ST_IDLE: if (load) begin
          state  <= ST_LOAD;
          page_q <= a_lat[AW-1:OFFW];
        end
        ST_LOAD: if (tmo) begin
          state <= ST_PROG;
          pcnt  <= '0;
        end
        ST_PROG: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PW'(PROG_CYC - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end

  logic [7:0] pbuf [PAGE];
  always_ff @(posedge clk)
    if (load) pbuf[loff] <= d_lat;

  logic [7:0] mem [DEPTH];
  always_ff @(posedge clk)
    if (sweep && vld[idx]) mem[{page_q, idx}] <= pbuf[idx];

  wire rd_en = !ce_q && !oe_q;
  assign data_oe  = rd_en;
  assign data_out = !rd_en ? 8'h00 :
                    (state == ST_PROG) ? {~last_b7, 7'b0} : mem[addr_q];

  initial a_r10_prog_fits_page: assert (PROG_CYC >= PAGE && AW > OFFW);

  a_r1_bus_enable: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe == (!$past(ce_n) && !$past(oe_n)));
  a_r7_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(page_q));
  a_r9_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG) |=> ($countones(vld) <= $past($countones(vld))));
  a_r10_idle_buffer_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (vld == '0));
  a_r8_timeout_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> (state != ST_PROG) || ($past(tmr) >= TW'(LOAD_TMO)));
endmodule

// File: tb/eeprom_page_seq_tb.sv
module eeprom_page_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9, GL = 3, TMO = 200, PROG = 300;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, wr_inhibit = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic data_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_seq #(.AW(AW), .GLITCH_CYC(GL), .LOAD_TMO(TMO), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_inhibit(wr_inhibit), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [DEPTH];
  bit known [DEPTH];
  bit m_loading = 0, last7 = 0;
  logic [AW-8:0] m_page;
  logic [7:0] mb [128];
  bit mv [128];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    @(negedge clk); d = data_out; en = data_oe; ce_n = 1; oe_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                    input int mode, input bit inh, input bit oelow);
    @(negedge clk);
    addr = AW'($urandom); data_in = d; oe_n = !oelow; wr_inhibit = inh;
    if (mode == 0) begin addr = a; ce_n = 0; we_n = 0; end
    else begin
      if (mode == 1) we_n = 0; else ce_n = 0;
      @(negedge clk); addr = a; ce_n = 0; we_n = 0;
    end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k < n) addr = AW'($urandom);
    end
    data_in = 8'($urandom);
    if (mode == 0) begin ce_n = 1; we_n = 1; end
    else begin
      if (mode == 1) ce_n = 1; else we_n = 1;
      @(negedge clk); ce_n = 1; we_n = 1;
    end
    oe_n = 1; wr_inhibit = 0;
  endtask

  function automatic void model_load(input logic [AW-1:0] a, input logic [7:0] d);
    if (!m_loading) begin m_loading = 1; m_page = a[AW-1:7]; end
    if (a[AW-1:7] == m_page) begin
      mb[a[6:0]] = d; mv[a[6:0]] = 1; last7 = d[7];
    end
  endfunction

  function automatic void model_commit();
    for (int i = 0; i < 128; i++)
      if (mv[i]) begin
        exp_mem[{m_page, 7'(i)}] = mb[i]; known[{m_page, 7'(i)}] = 1; mv[i] = 0;
      end
    m_loading = 0;
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] d; logic en;
    for (int i = 0; i < DEPTH; i++)
      if (known[i]) begin
        rd(AW'(i), d, en);
        chk(tag, d, exp_mem[i]);
      end
  endtask

  task automatic finish_page();
    logic [7:0] d; logic en;
    logic [AW-1:0] a;
    repeat (TMO + 30) @(negedge clk);
    rd(AW'($urandom), d, en);
    chk("R9 busy word", d, {~last7, 7'b0});
    a = {m_page, 7'($urandom)};
    wr(a, 8'($urandom), 4, 0, 0, 0);
    repeat (PROG + 20) @(negedge clk);
    model_commit();
    check_all("R10/R7/R3/R4 array contents");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic en;
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    for (int i = 0; i < 128; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset oe", {7'b0, data_oe}, 8'h00);
    chk("R1 reset data", data_out, 8'h00);

    // full 128-byte page, all strobe orderings
    for (int i = 0; i < 128; i++) begin
      a = {2'd0, 7'(i)}; d = 8'($urandom);
      wr(a, d, GL + (i % 3), i % 3, 0, 0);
      model_load(a, d);
    end
    finish_page();

    // R1 enable gating
    @(negedge clk); ce_n = 0; oe_n = 1;
    @(negedge clk); chk("R1 ce only", {7'b0, data_oe}, 8'h00);
    ce_n = 1; oe_n = 0;
    @(negedge clk); chk("R1 oe only", {data_out[0], 6'b0, data_oe}, 8'h00);
    oe_n = 1;
    rd(AW'(5), d, en);
    chk("R1 enabled", {7'b0, en}, 8'h01);
    chk("R2 read", d, exp_mem[5]);
    @(negedge clk); chk("R1 released", {7'b0, data_oe}, 8'h00);

    // R5 short pulses, R6 inhibit and OE-low writes
    wr(AW'(10), ~exp_mem[10], GL - 1, 0, 0, 0);
    wr(AW'(11), ~exp_mem[11], 1, 1, 0, 0);
    repeat (TMO + PROG + 40) @(negedge clk);
    rd(AW'(10), d, en); chk("R5 short pulse ignored", d, exp_mem[10]);
    rd(AW'(11), d, en); chk("R5 single-sample pulse ignored", d, exp_mem[11]);
    wr(AW'(12), ~exp_mem[12], 5, 0, 1, 0);
    wr(AW'(13), ~exp_mem[13], 5, 2, 0, 1);
    repeat (TMO + PROG + 40) @(negedge clk);
    rd(AW'(12), d, en); chk("R6 inhibit ignored", d, exp_mem[12]);
    rd(AW'(13), d, en); chk("R6 oe low ignored", d, exp_mem[13]);

    // random page sessions
    for (int s = 0; s < 12; s++) begin
      int nl;
      logic [1:0] pg;
      pg = 2'($urandom);
      nl = 1 + int'($urandom % 6);
      for (int i = 0; i < nl; i++) begin
        logic [1:0] p2;
        p2 = ($urandom % 5 == 0) ? pg ^ 2'(1 + $urandom % 3) : pg;
        a = {p2, 7'($urandom % 16)}; d = 8'($urandom);
        wr(a, d, GL + int'($urandom % 4), int'($urandom % 3), 0, 0);
        model_load(a, d);
        if (i == 0) begin
          a = {m_page, 7'($urandom % 16)};
          rd(a, d, en);
          if (known[a]) chk("R2 read during load", d, exp_mem[a]);
        end
        repeat ($urandom % 150) @(negedge clk);
      end
      finish_page();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule